// File: doc/BRIEF.md
# Chained Receive Command Queue

This block holds the receive buffer commands of a network controller that runs in command-chaining mode. The host can queue up to two receive commands. Each command names a buffer page. The receiver takes them in the order they were issued. A packet-start strobe claims the oldest queued entry. A packet-done strobe retires it, and the next entry then becomes the target page, just as if it had been issued at that moment.

The block keeps three status bits:
- an idle bit, set when no reception is queued;
- a packet flag, set only when a reception completes;
- a sticky overflow bit.

The packet flag has a one-deep backlog. If a second reception completes before the host has cleared the first, the second result is held. It appears as soon as the flag is cleared, and it raises a second interrupt. The receive-inhibit mask bit gates only the packet flag. The idle bit has its own separate enable.

Top module: `rx_chain_q`

## Requirements
- R1: After reset, rx_idle=1, busy=0, pkt_flag=0, ovf=0 and irq=0.
- R2: A command with cmd_op=0 (enable) stores cmd_page in the first free slot. cur_page shows the oldest stored page, and rx_idle is 0 while any slot is filled.
- R3: pkt_start sets busy when a slot is filled and no reception is active. pkt_start with an empty queue has no effect.
- R4: pkt_done during an active reception clears busy, sets pkt_flag and moves the second entry to the front, where cur_page then shows it.
- R5: A completion that arrives while pkt_flag is already 1 is held. The cycle after a clear command drops pkt_flag, pkt_flag becomes 1 again.
- R6: cmd_op=2 (clear) resets pkt_flag and ovf.
- R7: cmd_op=1 (disable) removes the oldest entry when that entry has not started. Two disables empty a full, idle queue.
- R8: A disable during an active reception removes the second entry if there is one. Otherwise it has no effect.
- R9: An enable while both slots are filled is ignored and sets ovf. The stored pages do not change.
- R10: irq is registered. Its value is (pkt_flag & ~rx_inhibit) | (rx_idle & idle_en), taken from the values one cycle earlier.
- R11: rx_inhibit masks only the pkt_flag term of irq. The idle term is unaffected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 0 enable, 1 disable, 2 clear, 3 no operation |
| cmd_page | input | PAGE_W | Buffer page for enable |
| pkt_start | input | 1 | Receiver began a packet |
| pkt_done | input | 1 | Receiver finished a packet |
| rx_inhibit | input | 1 | Mask bit gating pkt_flag from irq |
| idle_en | input | 1 | Enable for the idle term of irq |
| cur_page | output | PAGE_W | Page of the oldest queued entry |
| busy | output | 1 | Oldest entry is being received |
| rx_idle | output | 1 | No reception queued |
| pkt_flag | output | 1 | Packet received flag |
| ovf | output | 1 | Sticky enable-overflow flag |
| irq | output | 1 | Registered interrupt |

## Verification
Faults in this block show up at the ports quickly. If a slot's valid bit or the front pointer goes wrong, cur_page or rx_idle shows it on the first negedge after the command or strobe. A lost or duplicated completion backlog shows on pkt_flag one cycle after a clear. A masking fault shows on irq one cycle later than the flag it derives from. The bench uses the third page queued into a full queue as a marker: if that page ever surfaces at cur_page, R9 has failed.

// File: rtl/rx_chain_q.sv
module rx_chain_q #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              pkt_start,
  input  logic              pkt_done,
  input  logic              rx_inhibit,
  input  logic              idle_en,
  output logic [PAGE_W-1:0] cur_page,
  output logic              busy,
  output logic              rx_idle,
  output logic              pkt_flag,
  output logic              ovf,
  output logic              irq
);
  localparam logic [1:0] OP_EN = 2'd0, OP_DIS = 2'd1, OP_CLR = 2'd2;

  logic [PAGE_W-1:0] pg0, pg1, n_pg0, n_pg1;
  logic v0, v1, act, pend, n_v0, n_v1, n_act, n_pend, n_flag, n_ovf;

  wire do_en  = cmd_valid && cmd_op == OP_EN;
  wire do_dis = cmd_valid && cmd_op == OP_DIS;
  wire do_clr = cmd_valid && cmd_op == OP_CLR;
  wire done_ok = pkt_done && act;

  always_comb begin
    n_pg0 = pg0; n_pg1 = pg1; n_v0 = v0; n_v1 = v1; n_act = act;
    n_pend = pend; n_flag = pkt_flag; n_ovf = ovf;
    if (done_ok) begin
      n_pg0 = pg1; n_v0 = v1; n_v1 = 1'b0; n_act = 1'b0;
    end else if (pkt_start && v0 && !act) begin
      n_act = 1'b1;
    end
    if (do_en) begin
      if (!n_v0) begin n_v0 = 1'b1; n_pg0 = cmd_page; end
      else if (!n_v1) begin n_v1 = 1'b1; n_pg1 = cmd_page; end
      else n_ovf = 1'b1;
    end else if (do_dis) begin
      if (n_v0 && !n_act) begin n_pg0 = n_pg1; n_v0 = n_v1; n_v1 = 1'b0; end
      else if (n_act && n_v1) n_v1 = 1'b0;
    end
    if (do_clr) begin n_flag = 1'b0; n_ovf = 1'b0; end
    if (done_ok) begin
      if (n_flag) n_pend = 1'b1;
      else n_flag = 1'b1;
    end else if (!pkt_flag && pend) begin
      n_flag = 1'b1; n_pend = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg0 <= '0; pg1 <= '0; v0 <= 1'b0; v1 <= 1'b0; act <= 1'b0;
      pend <= 1'b0; pkt_flag <= 1'b0; ovf <= 1'b0; irq <= 1'b0;
    end else begin
      pg0 <= n_pg0; pg1 <= n_pg1; v0 <= n_v0; v1 <= n_v1; act <= n_act;
      pend <= n_pend; pkt_flag <= n_flag; ovf <= n_ovf;
      irq <= (pkt_flag & ~rx_inhibit) | (rx_idle & idle_en);
    end
  end

  assign cur_page = pg0;
  assign busy     = act;
  assign rx_idle  = ~v0;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_en && v0 && v1 && !done_ok) |=> (ovf && $stable(pg0) && $stable(pg1)));
  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_inhibit && !idle_en) |=> !irq);
  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_flag) |-> $past(done_ok || pend));
  assert_cancel_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_dis && v0 && v1 && !act && !pkt_start && !pkt_done) |=> (v0 && !v1 && pg0 == $past(pg1)));
  assert_busy_queued_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rx_idle);
  assert_active_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_dis && act && !pkt_done) |=> (busy && $stable(pg0)));
endmodule

// File: tb/rx_chain_q_tb.sv
module rx_chain_q_tb;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, pkt_start = 1'b0, pkt_done = 1'b0;
  logic rx_inhibit = 1'b0, idle_en = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic [3:0] cmd_page = '0, cur_page;
  logic busy, rx_idle, pkt_flag, ovf, irq;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rx_chain_q #(.PAGE_W(4)) u_dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_page(cmd_page), .pkt_start(pkt_start), .pkt_done(pkt_done),
    .rx_inhibit(rx_inhibit), .idle_en(idle_en), .cur_page(cur_page), .busy(busy),
    .rx_idle(rx_idle), .pkt_flag(pkt_flag), .ovf(ovf), .irq(irq));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; pkt_start = 1'b0; pkt_done = 1'b0;
    rx_inhibit = 1'b0; idle_en = 1'b0;
    tick(); tick(); rst_n = 1'b1; tick();
  endtask

  task automatic cmd(input logic [1:0] op, input logic [3:0] pg);
    cmd_valid = 1'b1; cmd_op = op; cmd_page = pg;
    tick();
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic pstart();
    pkt_start = 1'b1; tick(); pkt_start = 1'b0;
  endtask

  task automatic pdone();
    pkt_done = 1'b1; tick(); pkt_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "rx_idle", rx_idle, 1);
    check("R1", "busy", busy, 0);
    check("R1", "pkt_flag", pkt_flag, 0);
    check("R1", "ovf", ovf, 0);
    check("R1", "irq", irq, 0);
  endtask

  task automatic t_order();
    do_reset();
    cmd(2'd0, 4'd3);
    check("R2", "cur_page first", cur_page, 3);
    check("R2", "rx_idle", rx_idle, 0);
    cmd(2'd0, 4'd5);
    check("R2", "cur_page keeps oldest", cur_page, 3);
    cmd(2'd0, 4'd7);
    check("R9", "ovf set", ovf, 1);
    check("R9", "cur_page unchanged", cur_page, 3);
    pstart(); pdone();
    check("R9", "second entry is 5 not 7", cur_page, 5);
    pstart(); pdone();
    check("R9", "queue empty after two", rx_idle, 1);
    cmd(2'd2, 4'd0);
    check("R6", "ovf cleared", ovf, 0);
    check("R6", "pkt_flag cleared", pkt_flag, 0);
  endtask

  task automatic t_packets();
    do_reset();
    pstart();
    check("R3", "start on empty ignored", busy, 0);
    cmd(2'd0, 4'd2); cmd(2'd0, 4'd9);
    pstart();
    check("R3", "busy", busy, 1);
    check("R3", "cur_page", cur_page, 2);
    pdone();
    check("R4", "busy cleared", busy, 0);
    check("R4", "pkt_flag", pkt_flag, 1);
    check("R4", "advance", cur_page, 9);
    tick();
    check("R10", "irq from flag", irq, 1);
    pstart(); pdone();
    check("R5", "flag still set", pkt_flag, 1);
    check("R4", "idle after second", rx_idle, 1);
    cmd(2'd2, 4'd0);
    check("R6", "clear drops flag", pkt_flag, 0);
    tick();
    check("R5", "held result reasserts", pkt_flag, 1);
    cmd(2'd2, 4'd0);
    tick();
    check("R5", "no third result", pkt_flag, 0);
  endtask

  task automatic t_disable();
    do_reset();
    cmd(2'd0, 4'd1); cmd(2'd0, 4'd4);
    cmd(2'd1, 4'd0);
    check("R7", "oldest removed", cur_page, 4);
    check("R7", "one left", rx_idle, 0);
    cmd(2'd1, 4'd0);
    check("R7", "both removed", rx_idle, 1);
    cmd(2'd0, 4'd6); cmd(2'd0, 4'd8);
    pstart();
    cmd(2'd1, 4'd0);
    check("R8", "active kept", busy, 1);
    check("R8", "active page", cur_page, 6);
    pdone();
    check("R8", "second cancelled", rx_idle, 1);
    cmd(2'd1, 4'd0);
    check("R8", "disable on empty", rx_idle, 1);
    check("R8", "no ovf", ovf, 0);
  endtask

  task automatic t_mask();
    do_reset();
    idle_en = 1'b1; rx_inhibit = 1'b1;
    tick(); tick();
    check("R11", "idle term unmasked", irq, 1);
    cmd(2'd0, 4'd3);
    idle_en = 1'b0;
    pstart(); pdone();
    check("R11", "flag set", pkt_flag, 1);
    tick();
    check("R11", "flag masked", irq, 0);
    rx_inhibit = 1'b0;
    tick(); tick();
    check("R10", "flag unmasked", irq, 1);
    idle_en = 1'b1;
    cmd(2'd2, 4'd0);
    tick();
    check("R10", "idle term", irq, 1);
    idle_en = 1'b0;
    tick(); tick();
    check("R10", "all off", irq, 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_packets();
    t_disable();
    t_mask();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule